// File: doc/BRIEF.md
# Two-Digit Dimmed Display Timing Generator

This block drives a vacuum-fluorescent panel that is multiplexed over two digit grids. It counts an oscillator-rate enable into frames. Each frame splits into two equal slots: the first slot serves digit A and the second serves digit B. Inside each slot the active digit line comes on only after a short fixed guard interval. It then stays lit for a time that a dimmer code sets, and it stays dark for the rest of the slot. While a digit is lit, the segment lines carry that digit's pattern from the display registers. At every other moment the segment lines are low.

The dimmer code and both segment patterns are sampled into shadow registers only at a frame boundary, or continuously while the block is halted, so a write in the middle of a frame never cuts a slot short. A blank input and a non-zero sleep selection both halt the generator: the counter returns to zero, and every digit and segment line goes low. The high-voltage drivers sit outside this block.

Top module: `vfd_dimmer_timing`

## Requirements
- R1: A frame lasts 2·G·2^DIM_W enabled ticks (G = 2^GUARD_LOG2). Digit A may be lit only in the first half of the frame and digit B only in the second half, and the frame repeats without a gap.
- R2: The two digit lines are never high in the same cycle. `digit_out[0]` is digit A and `digit_out[1]` is digit B.
- R3: In each slot, the active digit stays low for the first G ticks (the guard).
- R4: With effective dimmer code D, the digit is lit for exactly G·D ticks, at slot positions G up to G·(D+1)−1. It is low for the rest of the slot. D = 0 leaves the digit dark.
- R5: The all-ones dimmer code is treated as all-ones minus one. With that code, the dark tail at the end of the slot equals the guard length G.
- R6: While digit A is lit, `seg_out` equals `seg_a_in` as sampled. While digit B is lit, it equals `seg_b_in` as sampled. Otherwise `seg_out` is all zeros.
- R7: Changes to `dim_in`, `seg_a_in` or `seg_b_in` take effect only from the next frame boundary, or immediately while the block is halted.
- R8: When `blank_n` is low, all outputs are low from the next clock. After release, the frame restarts at position 0 with digit A's slot.
- R9: When `sleep_sel` is any non-zero value, the block behaves exactly as when blanked. When `sleep_sel` is 0, it runs normally.
- R10: The position advances only in cycles where `tick` is high. Without ticks, the outputs hold their values.
- R11: Synchronous reset drives all outputs low and restarts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oscillator-rate enable; one frame position per high cycle |
| blank_n | input | 1 | Active-low blank; low halts and darkens |
| sleep_sel | input | 2 | Sleep selection; any non-zero value halts and darkens |
| dim_in | input | DIM_W | Dimmer code; lit time is G·code ticks |
| seg_a_in | input | SEG_N | Segment pattern for digit A |
| seg_b_in | input | SEG_N | Segment pattern for digit B |
| digit_out | output | 2 | Registered digit drives, bit 0 = A, bit 1 = B |
| seg_out | output | SEG_N | Registered segment drives |

## Verification
A wrong frame position shows up first as a digit edge at the wrong tick: a lit window starts early or late, or digit B lights in the first half-frame. The per-cycle comparison catches this within one slot. A shadow register that loads at the wrong time shows up as a lit window whose length or segment pattern changes partway through a frame, so it is visible before the frame ends. A halt path that fails to clear the counter shows up on the first release: digit A's window starts at some position other than G+1 clocks after release.

// File: rtl/vfd_dim_pkg.sv
package vfd_dim_pkg;

  typedef enum logic {
    SLOT_A = 1'b0,
    SLOT_B = 1'b1
  } slot_e;

  localparam int unsigned DIGITS = 2;

endpackage

// File: rtl/vfd_frame_counter.sv
module vfd_frame_counter #(
  parameter int unsigned FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halt,
  input  logic               tick,
  output logic [FRAME_W-1:0] cnt,
  output logic               wrap
);

  localparam logic [FRAME_W-1:0] LAST = {FRAME_W{1'b1}};

  assign wrap = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!halt && !tick) |=> $stable(cnt)); // R10

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    halt |=> (cnt == '0)); // R8

endmodule

// File: rtl/vfd_shadow_regs.sv
module vfd_shadow_regs #(
  parameter int unsigned DIM_W = 10,
  parameter int unsigned SEG_N = 41
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic             load,
  input  logic [DIM_W-1:0] dim_in,
  input  logic [SEG_N-1:0] seg_a_in,
  input  logic [SEG_N-1:0] seg_b_in,
  output logic [DIM_W-1:0] dim_q,
  output logic [SEG_N-1:0] seg_a_q,
  output logic [SEG_N-1:0] seg_b_q
);

  localparam logic [DIM_W-1:0] DIM_TOP = {{(DIM_W-1){1'b1}}, 1'b0};

  logic [DIM_W-1:0] dim_clamped;

  assign dim_clamped = (&dim_in) ? DIM_TOP : dim_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      dim_q   <= '0;
      seg_a_q <= '0;
      seg_b_q <= '0;
    end else if (halt || load) begin
      dim_q   <= dim_clamped;
      seg_a_q <= seg_a_in;
      seg_b_q <= seg_b_in;
    end
  end

  AST_SHADOW_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!halt && !load) |=> ($stable(dim_q) && $stable(seg_a_q) && $stable(seg_b_q))); // R7

  AST_DIM_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (halt || load) |=> !(&dim_q)); // R5

endmodule

// File: rtl/vfd_digit_window.sv
module vfd_digit_window #(
  parameter int unsigned DIM_W      = 10,
  parameter int unsigned GUARD_LOG2 = 1
) (
  input  logic [DIM_W+GUARD_LOG2-1:0] pos,
  input  logic [DIM_W-1:0]            dim,
  output logic                        lit
);

  localparam int unsigned SLOT_W = DIM_W + GUARD_LOG2;
  localparam logic [SLOT_W:0] GUARD = (SLOT_W+1)'(1) << GUARD_LOG2;

  logic [SLOT_W:0] stop_pos;
  logic [SLOT_W:0] pos_ext;

  assign pos_ext  = {1'b0, pos};
  assign stop_pos = ((SLOT_W+1)'(dim) + 1'b1) << GUARD_LOG2;
  assign lit      = (pos_ext >= GUARD) && (pos_ext < stop_pos);

endmodule

// File: rtl/vfd_dimmer_timing.sv
module vfd_dimmer_timing #(
  parameter int unsigned DIM_W      = 10,
  parameter int unsigned GUARD_LOG2 = 1,
  parameter int unsigned SEG_N      = 41
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             blank_n,
  input  logic [1:0]       sleep_sel,
  input  logic [DIM_W-1:0] dim_in,
  input  logic [SEG_N-1:0] seg_a_in,
  input  logic [SEG_N-1:0] seg_b_in,
  output logic [1:0]       digit_out,
  output logic [SEG_N-1:0] seg_out
);
  import vfd_dim_pkg::*;

  localparam int unsigned SLOT_W  = DIM_W + GUARD_LOG2;
  localparam int unsigned FRAME_W = SLOT_W + 1;
  localparam logic [SLOT_W-1:0] GUARD = SLOT_W'(1) << GUARD_LOG2;

  logic               halt;
  logic [FRAME_W-1:0] cnt;
  logic               wrap;
  logic [DIM_W-1:0]   dim_q;
  logic [SEG_N-1:0]   seg_a_q;
  logic [SEG_N-1:0]   seg_b_q;
  logic               lit;
  slot_e              slot;
  logic [SLOT_W-1:0]  pos;
  logic [SEG_N-1:0]   seg_nxt;
  logic [DIGITS-1:0]  digit_nxt;

  assign halt = !blank_n || (sleep_sel != 2'b00);
  assign slot = slot_e'(cnt[FRAME_W-1]);
  assign pos  = cnt[SLOT_W-1:0];

  vfd_frame_counter #(.FRAME_W(FRAME_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .halt (halt),
    .tick (tick),
    .cnt  (cnt),
    .wrap (wrap)
  );

  vfd_shadow_regs #(.DIM_W(DIM_W), .SEG_N(SEG_N)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .halt     (halt),
    .load     (wrap),
    .dim_in   (dim_in),
    .seg_a_in (seg_a_in),
    .seg_b_in (seg_b_in),
    .dim_q    (dim_q),
    .seg_a_q  (seg_a_q),
    .seg_b_q  (seg_b_q)
  );

  vfd_digit_window #(.DIM_W(DIM_W), .GUARD_LOG2(GUARD_LOG2)) u_win (
    .pos (pos),
    .dim (dim_q),
    .lit (lit)
  );

  assign digit_nxt[0] = lit && (slot == SLOT_A);
  assign digit_nxt[1] = lit && (slot == SLOT_B);

  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    assign seg_nxt[i] = (digit_nxt[0] && seg_a_q[i]) || (digit_nxt[1] && seg_b_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      digit_out <= '0;
      seg_out   <= '0;
    end else begin
      digit_out <= digit_nxt;
      seg_out   <= seg_nxt;
    end
  end

  AST_DIGIT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(digit_out[0] && digit_out[1])); // R2

  AST_SEG_GATED: assert property (@(posedge clk) disable iff (rst)
    (digit_out == 2'b00) |-> (seg_out == '0)); // R6

  AST_GUARD_DARK: assert property (@(posedge clk) disable iff (rst)
    (pos < GUARD) |=> (digit_out == 2'b00)); // R3

  AST_HALT_DARK: assert property (@(posedge clk) disable iff (rst)
    halt |=> ((digit_out == 2'b00) && (seg_out == '0))); // R8

  AST_B_SECOND_HALF: assert property (@(posedge clk) disable iff (rst)
    (!halt && !cnt[FRAME_W-1]) |=> !digit_out[1]); // R1

endmodule

// File: tb/vfd_dimmer_timing_tb_top.sv
module vfd_dimmer_timing_tb_top;

  localparam int DW = 4;
  localparam int GL = 1;
  localparam int SN = 5;
  localparam int G  = 1 << GL;
  localparam int S  = G << DW;
  localparam int F  = 2 * S;
  localparam int DMAX = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          tick;
  logic          blank_n;
  logic [1:0]    sleep_sel;
  logic [DW-1:0] dim_in;
  logic [SN-1:0] seg_a_in;
  logic [SN-1:0] seg_b_in;
  logic [1:0]    digit_out;
  logic [SN-1:0] seg_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int m_cnt, m_dm, m_da, m_db;
  int e_g, e_seg;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  vfd_dimmer_timing #(.DIM_W(DW), .GUARD_LOG2(GL), .SEG_N(SN)) dut_i (
    .clk, .rst, .tick, .blank_n, .sleep_sel, .dim_in,
    .seg_a_in, .seg_b_in, .digit_out, .seg_out
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    bit halted;
    int slot, pos, lit, deff;
    string req;
    halted = rst || !blank_n || (sleep_sel != 2'b00);
    slot = m_cnt / S;
    pos  = m_cnt % S;
    lit  = (pos >= G) && (pos < G * (m_dm + 1));
    if (halted) begin
      e_g = 0; e_seg = 0;
    end else begin
      e_g   = lit ? (slot ? 2 : 1) : 0;
      e_seg = lit ? (slot ? m_db : m_da) : 0;
    end
    if (halted || (tick && m_cnt == F - 1)) begin
      deff = int'(dim_in);
      if (deff == DMAX) deff = DMAX - 1;
      m_dm = deff; m_da = int'(seg_a_in); m_db = int'(seg_b_in);
    end
    if (halted) m_cnt = 0;
    else if (tick) m_cnt = (m_cnt + 1) % F;
    req = rst ? "R11" : (!blank_n ? "R8" : (sleep_sel != 0 ? "R9" : "R4"));
    @(posedge clk);
    @(negedge clk);
    check(int'(digit_out) == e_g, req, int'(digit_out), e_g);
    check(int'(seg_out) == e_seg, (req == "R4") ? "R6" : req, int'(seg_out), e_seg);
    check(digit_out != 2'b11, "R2", int'(digit_out), 0);
  endtask

  task automatic run_count(input int n, output int c1, output int c2, output int first1);
    c1 = 0; c2 = 0; first1 = -1;
    for (int j = 1; j <= n; j++) begin
      step();
      if (digit_out[0]) begin c1++; if (first1 < 0) first1 = j; end
      if (digit_out[1]) c2++;
    end
  endtask

  task automatic restart();
    blank_n = 1'b0; step(); blank_n = 1'b1;
  endtask

  initial begin
    int c1, c2, f1, deff;
    rst = 1'b1; tick = 1'b1; blank_n = 1'b1; sleep_sel = 2'b00;
    dim_in = '0; seg_a_in = '0; seg_b_in = '0;
    m_cnt = 0; m_dm = 0; m_da = 0; m_db = 0;
    // R11: reset darkens outputs
    for (int i = 0; i < 3; i++) step();
    check(digit_out == 2'b00 && seg_out == '0, "R11", int'(digit_out), 0);
    rst = 1'b0;

    // R3 R4 R5 R1: sweep every dimmer code over one full frame
    seg_a_in = 5'b10101; seg_b_in = 5'b01011;
    for (int d = 0; d <= DMAX; d++) begin
      dim_in = DW'(d);
      restart();
      run_count(F, c1, c2, f1);
      deff = (d == DMAX) ? DMAX - 1 : d;
      check(c1 == G * deff, (d == DMAX) ? "R5" : "R4", c1, G * deff);
      check(c2 == G * deff, (d == DMAX) ? "R5" : "R1", c2, G * deff);
      if (deff > 0) check(f1 == G + 1, "R3", f1, G + 1);
    end
    // R5: all-ones code leaves a dark tail equal to the guard
    dim_in = DW'(DMAX);
    restart();
    run_count(G * DMAX, c1, c2, f1);
    check(digit_out == 2'b01, "R5", int'(digit_out), 1);
    step();
    check(digit_out == 2'b00, "R5", int'(digit_out), 0);

    // R6: several segment patterns, full frames
    dim_in = DW'(9);
    for (int p = 0; p < 8; p++) begin
      seg_a_in = SN'(p * 7 + 3); seg_b_in = SN'(~(p * 5));
      restart();
      for (int j = 0; j < F; j++) step();
    end

    // R7: mid-frame change waits for the frame boundary
    dim_in = DW'(10); seg_a_in = 5'b11111;
    restart();
    for (int j = 0; j < G * 4; j++) step();
    dim_in = DW'(3); seg_a_in = 5'b00001;
    run_count(F - G * 4, c1, c2, f1);
    check(c2 == G * 10, "R7", c2, G * 10);
    run_count(F, c1, c2, f1);
    check(c1 == G * 3 && c2 == G * 3, "R7", c1, G * 3);

    // R10: random tick gating, plus an explicit hold window
    dim_in = DW'(12);
    restart();
    for (int j = 0; j < 1500; j++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick = lfsr[0];
      step();
    end
    tick = 1'b1;
    for (int j = 0; j < G + 3; j++) step();
    begin
      logic [1:0] hold_g;
      logic [SN-1:0] hold_s;
      hold_g = digit_out; hold_s = seg_out;
      tick = 1'b0;
      for (int j = 0; j < 6; j++) step();
      check(digit_out == hold_g && seg_out == hold_s, "R10", int'(digit_out), int'(hold_g));
      tick = 1'b1;
    end

    // R8: blank mid-frame, then restart at position 0
    for (int j = 0; j < 9; j++) step();
    blank_n = 1'b0;
    for (int j = 0; j < 4; j++) step();
    check(digit_out == 2'b00 && seg_out == '0, "R8", int'(digit_out), 0);
    blank_n = 1'b1;
    run_count(G + 1, c1, c2, f1);
    check(f1 == G + 1, "R8", f1, G + 1);

    // R9: every non-zero sleep code darkens; zero resumes
    for (int sc = 1; sc < 4; sc++) begin
      for (int j = 0; j < 20; j++) step();
      sleep_sel = 2'(sc);
      for (int j = 0; j < 5; j++) step();
      check(digit_out == 2'b00 && seg_out == '0, "R9", int'(digit_out), 0);
      sleep_sel = 2'b00;
      run_count(G + 1, c1, c2, f1);
      check(f1 == G + 1, "R9", f1, G + 1);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule